// File: doc/BRIEF.md
# Single-Sector Write-Back Cache

This block places one sector-sized buffer between a client that reads and writes single bytes and a storage back end that only moves whole 512-byte sectors. A byte address is split into a sector number (upper bits) and an offset inside the sector (low nine bits). The block remembers which sector the buffer holds and whether the buffer has been modified since it was loaded.

A request to the buffered sector is served from the buffer with no back-end traffic. A request to any other sector is held off while the block first writes the buffer back to its own sector when it is modified, and then loads the requested sector. After the load, the held request is served from the buffer. A flush input writes a modified buffer back without loading anything.

Out of reset the block loads sector 0 before it accepts any client request. The back end sees a command (direction and sector number) followed by a stream of 512 bytes in ascending offset order, each byte moving on a valid/ready handshake.

Top module: `sector_wb_cache`

## Requirements
- R1: The sector number of a request is `reqAddr[ADDR_W-1:9]` and its offset is `reqAddr[8:0]`. An accepted read returns the byte at that offset of that sector on `rspData`, with `rspValid` high in the cycle after acceptance; `rspValid` is high at no other time.
- R2: After reset the block issues one back-end read command for sector 0, loads the buffer, and keeps `reqReady` low until that load is complete; the buffer is then clean.
- R3: A read whose sector equals the buffered sector is accepted in the same cycle it is presented, with no back-end command.
- R4: A read to another sector while the buffer is clean causes exactly one back-end read command, for the requested sector.
- R5: A miss while the buffer is modified causes a back-end write command for the buffered sector carrying all 512 buffered bytes, followed by a read command for the requested sector.
- R6: After any load the buffered sector is the requested one and the buffer is clean, so a following access to that sector causes no back-end command and a following miss causes no write-back.
- R7: A write whose sector equals the buffered sector updates that byte in the buffer with no back-end command and marks the buffer modified.
- R8: A write to another sector performs the same write-back-if-modified and load sequence as a read miss, then stores the byte in the loaded buffer and marks it modified.
- R9: `reqReady` stays low while any back-end command or data transfer is in progress; a back-end command, once raised, stays raised with a stable direction and sector until accepted.
- R10: A flush request on a modified buffer issues one back-end write command of the buffered sector, then `flushDone` pulses and the buffer is clean; on a clean buffer `flushDone` is high in the same cycle with no back-end command.
- R11: When `flushReq` and a client request are present together while idle, the flush is served first and `reqReady` stays low while `flushReq` is high.
- R12: Each back-end data phase moves exactly 512 bytes in ascending offset order, and the write and read streams are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Client request present; held until accepted |
| reqWrite | input | 1 | 1 = byte write, 0 = byte read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 8 | Byte to write |
| reqReady | output | 1 | Request accepted this cycle |
| rspValid | output | 1 | Read data valid (cycle after read acceptance) |
| rspData | output | 8 | Read data |
| flushReq | input | 1 | Write back the buffer if modified; held until flushDone |
| flushDone | output | 1 | Flush completed |
| beCmdValid | output | 1 | Back-end command present |
| beCmdWrite | output | 1 | 1 = sector write, 0 = sector read |
| beCmdSector | output | ADDR_W-9 | Sector number of the command |
| beCmdReady | input | 1 | Back end accepts the command |
| beWrValid | output | 1 | Write stream byte present |
| beWrData | output | 8 | Write stream byte |
| beWrReady | input | 1 | Back end takes the write byte |
| beRdValid | input | 1 | Read stream byte present |
| beRdData | input | 8 | Read stream byte |
| beRdReady | output | 1 | Block takes the read byte |

## Verification
The flush and a client request can land in the same idle cycle. The bench raises both together while the buffer is modified and while it is clean, and checks that the client is not accepted until `flushDone` has been seen and the flush dropped, that only a write-back command (or none) appears during the flush, and that the request then completes with its own expected command sequence and data.

// File: rtl/sector_wb_cache_pkg.sv
package sector_wb_cache_pkg;

  typedef enum logic [2:0] {
    ST_FILL_CMD   = 3'd0,
    ST_FILL_DATA  = 3'd1,
    ST_EVICT_CMD  = 3'd2,
    ST_EVICT_DATA = 3'd3,
    ST_IDLE       = 3'd4
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic idxClr;      // restart the stream byte counter
    logic idxInc;      // advance the stream byte counter
    logic fillWr;      // store a back-end byte at the counter
    logic clientWr;    // store the client byte at the request offset
    logic setDirty;
    logic clrDirty;
    logic commitFill;  // buffered sector := target sector
    logic latchTarget; // target sector := request sector
    logic pickSaved;   // command sector is the buffered one
    logic rspLoad;     // capture read data for the client
  } dpStrobe_t;

endpackage

// File: rtl/sector_wb_cache_datapath.sv
module sector_wb_cache_datapath
  import sector_wb_cache_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SECTOR_BYTES = 512,
  parameter int DATA_W       = 8
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  dpStrobe_t                                 stb,
  input  logic [ADDR_W-1:0]                         reqAddr,
  input  logic [DATA_W-1:0]                         reqWdata,
  input  logic [DATA_W-1:0]                         beRdData,
  output logic                                      hit,
  output logic                                      dirty,
  output logic                                      idxLast,
  output logic [ADDR_W-$clog2(SECTOR_BYTES)-1:0]    beCmdSector,
  output logic [DATA_W-1:0]                         beWrData,
  output logic [DATA_W-1:0]                         rspData
);
  localparam int OFF_W = $clog2(SECTOR_BYTES);
  localparam int SEC_W = ADDR_W - OFF_W;

  logic [DATA_W-1:0] buffer [SECTOR_BYTES];
  logic [OFF_W-1:0]  idx;
  logic [SEC_W-1:0]  savedSector;
  logic [SEC_W-1:0]  targetSector;
  logic [SEC_W-1:0]  reqSector;
  logic [OFF_W-1:0]  reqOffset;

  assign reqSector = reqAddr[ADDR_W-1:OFF_W];
  assign reqOffset = reqAddr[OFF_W-1:0];
  assign hit       = (reqSector == savedSector);
  assign idxLast   = (idx == OFF_W'(SECTOR_BYTES - 1));
  assign beCmdSector = stb.pickSaved ? savedSector : targetSector;
  assign beWrData  = buffer[idx];

  always_ff @(posedge clk) begin
    if (rst)              idx <= '0;
    else if (stb.idxClr)  idx <= '0;
    else if (stb.idxInc)  idx <= idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      savedSector  <= '0;
      targetSector <= '0;
    end else begin
      if (stb.latchTarget) targetSector <= reqSector;
      if (stb.commitFill)  savedSector  <= targetSector;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               dirty <= 1'b0;
    else if (stb.clrDirty) dirty <= 1'b0;
    else if (stb.setDirty) dirty <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.fillWr)        buffer[idx]       <= beRdData;
    else if (stb.clientWr) buffer[reqOffset] <= reqWdata;
  end

  always_ff @(posedge clk) begin
    if (rst)              rspData <= '0;
    else if (stb.rspLoad) rspData <= buffer[reqOffset];
  end

endmodule

// File: rtl/sector_wb_cache_ctrl.sv
module sector_wb_cache_ctrl
  import sector_wb_cache_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      flushReq,
  input  logic      hit,
  input  logic      dirty,
  input  logic      idxLast,
  input  logic      beCmdReady,
  input  logic      beWrReady,
  input  logic      beRdValid,
  output logic      reqReady,
  output logic      rspValid,
  output logic      flushDone,
  output logic      beCmdValid,
  output logic      beCmdWrite,
  output logic      beWrValid,
  output logic      beRdReady,
  output dpStrobe_t stb
);
  ctlState_t state, stateNext;
  logic      fillAfter, fillAfterNext;

  always_comb begin
    stateNext     = state;
    fillAfterNext = fillAfter;
    stb           = '0;
    reqReady      = 1'b0;
    flushDone     = 1'b0;
    beCmdValid    = 1'b0;
    beCmdWrite    = 1'b0;
    beWrValid     = 1'b0;
    beRdReady     = 1'b0;
    case (state)
      ST_FILL_CMD: begin
        beCmdValid = 1'b1;
        stb.idxClr = 1'b1;
        if (beCmdReady) stateNext = ST_FILL_DATA;
      end
      ST_FILL_DATA: begin
        beRdReady = 1'b1;
        if (beRdValid) begin
          stb.fillWr = 1'b1;
          stb.idxInc = 1'b1;
          if (idxLast) begin
            stb.commitFill = 1'b1;
            stb.clrDirty   = 1'b1;
            stateNext      = ST_IDLE;
          end
        end
      end
      ST_EVICT_CMD: begin
        beCmdValid    = 1'b1;
        beCmdWrite    = 1'b1;
        stb.pickSaved = 1'b1;
        stb.idxClr    = 1'b1;
        if (beCmdReady) stateNext = ST_EVICT_DATA;
      end
      ST_EVICT_DATA: begin
        beWrValid = 1'b1;
        if (beWrReady) begin
          stb.idxInc = 1'b1;
          if (idxLast) begin
            stb.clrDirty = 1'b1;
            if (fillAfter) begin
              stateNext = ST_FILL_CMD;
            end else begin
              flushDone = 1'b1;
              stateNext = ST_IDLE;
            end
          end
        end
      end
      ST_IDLE: begin
        if (flushReq) begin
          if (!dirty) begin
            flushDone = 1'b1;
          end else begin
            fillAfterNext = 1'b0;
            stateNext     = ST_EVICT_CMD;
          end
        end else if (reqValid) begin
          if (hit) begin
            reqReady = 1'b1;
            if (reqWrite) begin
              stb.clientWr = 1'b1;
              stb.setDirty = 1'b1;
            end else begin
              stb.rspLoad  = 1'b1;
            end
          end else begin
            stb.latchTarget = 1'b1;
            if (dirty) begin
              fillAfterNext = 1'b1;
              stateNext     = ST_EVICT_CMD;
            end else begin
              stateNext     = ST_FILL_CMD;
            end
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_FILL_CMD;
      fillAfter <= 1'b0;
      rspValid  <= 1'b0;
    end else begin
      state     <= stateNext;
      fillAfter <= fillAfterNext;
      rspValid  <= stb.rspLoad;
    end
  end

endmodule

// File: rtl/sector_wb_cache.sv
module sector_wb_cache
  import sector_wb_cache_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int SECTOR_BYTES = 512
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   reqValid,
  input  logic                                   reqWrite,
  input  logic [ADDR_W-1:0]                      reqAddr,
  input  logic [7:0]                             reqWdata,
  output logic                                   reqReady,
  output logic                                   rspValid,
  output logic [7:0]                             rspData,
  input  logic                                   flushReq,
  output logic                                   flushDone,
  output logic                                   beCmdValid,
  output logic                                   beCmdWrite,
  output logic [ADDR_W-$clog2(SECTOR_BYTES)-1:0] beCmdSector,
  input  logic                                   beCmdReady,
  output logic                                   beWrValid,
  output logic [7:0]                             beWrData,
  input  logic                                   beWrReady,
  input  logic                                   beRdValid,
  input  logic [7:0]                             beRdData,
  output logic                                   beRdReady
);
  dpStrobe_t stb;
  logic      hit;
  logic      dirty;
  logic      idxLast;

  sector_wb_cache_ctrl i_ctrl (
    .clk, .rst, .reqValid, .reqWrite, .flushReq,
    .hit, .dirty, .idxLast, .beCmdReady, .beWrReady, .beRdValid,
    .reqReady, .rspValid, .flushDone, .beCmdValid, .beCmdWrite,
    .beWrValid, .beRdReady, .stb
  );

  sector_wb_cache_datapath #(
    .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES), .DATA_W(8)
  ) i_dp (
    .clk, .rst, .stb, .reqAddr, .reqWdata, .beRdData,
    .hit, .dirty, .idxLast, .beCmdSector, .beWrData, .rspData
  );

endmodule

// File: rtl/sector_wb_cache_checker.sv
module sector_wb_cache_checker #(
  parameter int ADDR_W       = 20,
  parameter int SECTOR_BYTES = 512
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   reqValid,
  input logic                                   reqWrite,
  input logic                                   reqReady,
  input logic                                   rspValid,
  input logic                                   flushReq,
  input logic                                   flushDone,
  input logic                                   beCmdValid,
  input logic                                   beCmdWrite,
  input logic [ADDR_W-$clog2(SECTOR_BYTES)-1:0] beCmdSector,
  input logic                                   beCmdReady,
  input logic                                   beWrValid,
  input logic                                   beWrReady,
  input logic                                   beRdReady
);
  localparam int CNT_W = $clog2(SECTOR_BYTES) + 1;
  logic [CNT_W-1:0] wrBeats;

  always_ff @(posedge clk) begin
    if (rst)                            wrBeats <= '0;
    else if (beCmdValid && beCmdReady)  wrBeats <= '0;
    else if (beWrValid && beWrReady)    wrBeats <= wrBeats + 1'b1;
  end

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (beCmdValid && !beCmdReady) |=> (beCmdValid && $stable(beCmdWrite) && $stable(beCmdSector)));

  p_busy_blocks_client_r9: assert property (@(posedge clk) disable iff (rst)
    (beCmdValid || beWrValid || beRdReady) |-> !reqReady);

  p_flush_first_r11: assert property (@(posedge clk) disable iff (rst)
    flushReq |-> !reqReady);

  p_read_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !reqWrite) |=> rspValid);

  p_rsp_source_r1: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $past(reqValid && reqReady && !reqWrite));

  p_one_stream_r12: assert property (@(posedge clk) disable iff (rst)
    beWrValid |-> !beRdReady);

  p_whole_sector_r12: assert property (@(posedge clk) disable iff (rst)
    (beCmdValid && beCmdReady && wrBeats != '0) |-> (wrBeats == CNT_W'(SECTOR_BYTES)));

  p_flush_last_beat_r10: assert property (@(posedge clk) disable iff (rst)
    (flushDone && beWrValid) |-> (wrBeats == CNT_W'(SECTOR_BYTES - 1)));

  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    flushDone |=> (!beCmdValid && !beWrValid));

endmodule

bind sector_wb_cache sector_wb_cache_checker #(
  .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)
) i_chk (.*);

// File: tb/test_sector_wb_cache.sv
module test_sector_wb_cache;
  localparam int ADDR_W = 12;
  localparam int SB     = 512;
  localparam int SEC_W  = ADDR_W - 9;
  localparam int NBYTES = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, rspValid, flushDone;
  logic [7:0] rspData;
  logic flushReq = 1'b0;
  logic beCmdValid, beCmdWrite, beWrValid, beRdReady;
  logic [SEC_W-1:0] beCmdSector;
  logic beCmdReady = 1'b0, beWrReady = 1'b0, beRdValid = 1'b0;
  logic [7:0] beWrData;
  logic [7:0] beRdData = '0;

  always #2 clk = ~clk;

  sector_wb_cache #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SB)) i_sector_wb_cache (
    .clk, .rst, .reqValid, .reqWrite, .reqAddr, .reqWdata, .reqReady,
    .rspValid, .rspData, .flushReq, .flushDone, .beCmdValid, .beCmdWrite,
    .beCmdSector, .beCmdReady, .beWrValid, .beWrData, .beWrReady,
    .beRdValid, .beRdData, .beRdReady
  );

  logic [7:0] store  [NBYTES];
  logic [7:0] golden [NBYTES];
  int  logCnt;
  bit  logW [8];
  int  logS [8];
  int  total = 0, bad = 0;
  int  bSaved;
  bit  bDirty;

  function automatic logic [7:0] seedByte(int a);
    return 8'((a * 37 + 11) ^ (a >> 4));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // back-end model with random stalls
  initial begin
    bit w;
    int s;
    int i;
    void'($urandom(77));
    forever begin
      @(negedge clk);
      if (!rst && beCmdValid) begin
        w = beCmdWrite;
        s = int'(beCmdSector);
        beCmdReady = 1'b1;
        @(negedge clk);
        beCmdReady = 1'b0;
        if (logCnt < 8) begin
          logW[logCnt] = w;
          logS[logCnt] = s;
        end
        logCnt++;
        i = 0;
        while (i < SB) begin
          bit stall;
          stall = ($urandom % 4) == 0;
          if (w) begin
            beWrReady = !stall;
            if (!stall && beWrValid) begin
              store[s*SB + i] = beWrData;
              i++;
            end
          end else begin
            beRdValid = !stall;
            beRdData  = store[s*SB + i];
            if (!stall && beRdReady) i++;
          end
          @(negedge clk);
        end
        beWrReady = 1'b0;
        beRdValid = 1'b0;
      end
    end
  end

  // wait for acceptance of an already-driven request; returns cycles waited
  task automatic waitAccept(output int waits);
    waits = 0;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
      waits++;
    end
  endtask

  task automatic finishAccess(bit w, int addr, logic [7:0] d, int waits, int nExp,
                              bit eW0, int eS0, int eS1, string tag);
    logic [7:0] rd;
    int sec;
    sec = addr / SB;
    @(negedge clk);
    reqValid = 1'b0;
    rd = rspData;
    chk(logCnt == nExp, {tag, " command count"}, logCnt, nExp);
    if (nExp >= 1) begin
      chk(logW[0] == eW0 && logS[0] == eS0, {tag, " first command"}, logS[0], eS0);
    end
    if (nExp == 2) begin
      chk(logW[1] == 1'b0 && logS[1] == eS1, {tag, " fill after write-back R5"}, logS[1], eS1);
      for (int k = 0; k < SB; k++) begin
        if (store[eS0*SB + k] != golden[eS0*SB + k]) begin
          chk(1'b0, "R5 write-back content", int'(store[eS0*SB + k]), int'(golden[eS0*SB + k]));
          break;
        end
      end
    end
    if (nExp > 0) chk(waits >= SB, "R9 client held during transfer", waits, SB);
    else          chk(waits == 0, "R3 R7 hit accepted at once", waits, 0);
    if (w) begin
      golden[addr] = d;
      chk(rspValid == 1'b0, "R1 no response for write", int'(rspValid), 0);
    end else begin
      chk(rspValid == 1'b1 && rd == golden[addr], {tag, " R1 read data"}, int'(rd), int'(golden[addr]));
    end
    bSaved = sec;
    bDirty = (nExp > 0) ? w : (bDirty | w);
  endtask

  task automatic access(bit w, int addr, logic [7:0] d);
    int sec, nExp, waits;
    bit eW0;
    int eS0;
    string tag;
    sec = addr / SB;
    if (sec == bSaved) begin
      nExp = 0; eW0 = 0; eS0 = 0; tag = w ? "R7 write hit" : "R3 read hit";
    end else if (bDirty) begin
      nExp = 2; eW0 = 1; eS0 = bSaved; tag = w ? "R8 write miss dirty" : "R5 read miss dirty";
    end else begin
      nExp = 1; eW0 = 0; eS0 = sec; tag = w ? "R8 write miss clean" : "R4 R6 read miss clean";
    end
    @(negedge clk);
    logCnt = 0;
    reqValid = 1'b1; reqWrite = w; reqAddr = ADDR_W'(addr); reqWdata = d;
    waitAccept(waits);
    finishAccess(w, addr, d, waits, nExp, eW0, eS0, sec, tag);
  endtask

  task automatic flush(string tag);
    bit wasDirty;
    wasDirty = bDirty;
    @(negedge clk);
    logCnt = 0;
    flushReq = 1'b1;
    #1;
    while (!flushDone) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    flushReq = 1'b0;
    chk(logCnt == (wasDirty ? 1 : 0), {tag, " R10 flush commands"}, logCnt, wasDirty ? 1 : 0);
    if (wasDirty) chk(logW[0] && logS[0] == bSaved, {tag, " R10 flush sector"}, logS[0], bSaved);
    bDirty = 0;
  endtask

  task automatic compareAll(string tag);
    int mism;
    mism = 0;
    for (int k = 0; k < NBYTES; k++) if (store[k] != golden[k]) mism++;
    chk(mism == 0, tag, mism, 0);
  endtask

  // flush and client request raised in the same cycle
  task automatic flushWithRequest(bit w, int addr, logic [7:0] d);
    int waits, sec, nExp;
    bit wasDirty;
    sec = addr / SB;
    wasDirty = bDirty;
    @(negedge clk);
    logCnt = 0;
    flushReq = 1'b1;
    reqValid = 1'b1; reqWrite = w; reqAddr = ADDR_W'(addr); reqWdata = d;
    #1;
    chk(reqReady == 1'b0, "R11 request waits for flush", int'(reqReady), 0);
    while (!flushDone) begin
      chk(reqReady == 1'b0, "R11 no accept during flush", int'(reqReady), 0);
      @(negedge clk);
      #1;
    end
    chk(logCnt == (wasDirty ? 1 : 0), "R11 R10 only write-back before done", logCnt, wasDirty ? 1 : 0);
    @(negedge clk);
    flushReq = 1'b0;
    bDirty = 0;
    logCnt = 0;
    nExp = (sec == bSaved) ? 0 : 1;
    waitAccept(waits);
    finishAccess(w, addr, d, waits, nExp, 1'b0, sec, sec, "R11 request after flush");
  endtask

  initial begin
    void'($urandom(1234));
    for (int k = 0; k < NBYTES; k++) begin
      store[k]  = seedByte(k);
      golden[k] = seedByte(k);
    end
    logCnt = 0;
    repeat (4) @(negedge clk);
    chk(rspValid == 0 && flushDone == 0 && beWrValid == 0, "R2 reset outputs idle",
        int'(rspValid) + int'(flushDone) + int'(beWrValid), 0);
    rst = 1'b0;
    // R2: preload of sector 0 looks like a clean miss to sector 0
    bSaved = -1; bDirty = 0;
    access(1'b0, 5, 8'h00);
    access(1'b0, 511, 8'h00);               // R3 hit, last offset
    access(1'b1, 0, 8'hA5);                 // R7 write hit, first offset
    access(1'b0, 0, 8'h00);                 // read back written byte
    access(1'b0, SB + 3, 8'h00);            // R5 dirty read miss
    access(1'b0, 2*SB + 9, 8'h00);          // R4 clean miss, R6 clean after fill
    access(1'b1, 3*SB + 511, 8'h3C);        // R8 clean write miss
    access(1'b0, 3*SB + 511, 8'h00);
    access(1'b1, 7*SB, 8'hC3);              // R8 dirty write miss
    flush("dirty");
    flush("clean");
    compareAll("R10 back end matches after flush");
    access(1'b1, 7*SB + 1, 8'h11);
    flushWithRequest(1'b0, 7*SB + 1, 8'h00); // dirty flush + hit read
    flushWithRequest(1'b0, 4*SB + 2, 8'h00); // clean flush + miss read
    // random phase with locality
    for (int n = 0; n < 150; n++) begin
      int sec, addr;
      bit w;
      if (($urandom % 4) != 0) sec = bSaved;
      else                     sec = int'($urandom % (NBYTES / SB));
      addr = sec * SB + int'($urandom % SB);
      w = ($urandom % 2) == 1;
      if (($urandom % 20) == 0) flush("random");
      access(w, addr, 8'($urandom));
    end
    flush("final");
    compareAll("R10 R12 final back end image");
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    finishRun();
  end

endmodule